// File: doc/BRIEF.md
# Rising-Delay Crosstalk Tester for a Data Bus

This engine checks every line of a parallel data bus for rising-delay crosstalk faults at full clock rate. For each line in turn it drives a two-cycle vector pair onto the transmit port. The first vector holds the victim line low and every other line high. On the next cycle the second vector raises only the victim line while all neighbours fall together. The value seen on the receive port in that second cycle is sampled at once, so the victim's rising edge gets a single clock period to arrive.

The received second vectors are not compared one by one. They are summed into an accumulator that is cleared when a run is accepted. A healthy bus adds one distinct power of two per line, so a clean run ends with every bit of the sum set. If a line's rising edge is late, that line contributes zero, and its bit in the final sum is clear. The sum is stored in a result register that holds until the next run completes.

A received second vector can carry bits other than the victim. Such a value could produce carries that corrupt the per-line reading. When this happens a sticky anomaly flag is raised.

The controller is a four-state machine:
- `PH_IDLE` moves to `PH_PRE` when start is accepted. This clears the sum and the anomaly flag and selects the top line.
- `PH_PRE` drives the first vector and always moves to `PH_HIT`.
- `PH_HIT` drives the second vector and accumulates the received value. It returns to `PH_PRE` with the next lower line. After line 0 it moves to `PH_REPORT` and writes the result register.
- `PH_REPORT` raises done for one cycle and always returns to `PH_IDLE`.

Top module: `rise_delay_tester`

## Requirements
- R1: After reset, result is 0, anomaly is 0 and done is 0. While idle the transmit port carries all zeros.
- R2: A run visits the lines from the most significant (W-1) down to line 0. Each line is tested exactly once, so a run lasts 2*W cycles of vectors.
- R3: For victim line k, the transmit port carries ~(1<<k) for one cycle, then (1<<k) on the very next cycle.
- R4: In the second-vector cycle, the receive port value is added modulo 2^W to an accumulator. The accumulator is cleared on the cycle start is accepted.
- R5: With a fault-free bus the final sum is all ones. A rising-delay fault on line k (received bit k stays 0 in its second cycle) leaves result bit k at 0, for any combination of faulty lines.
- R6: The result register is written only at the end of a run's last test. It holds its value through idle time and through the following run until that run's end.
- R7: done is high for exactly one cycle, 2*W+1 cycles after the clock edge that accepts start. The result and anomaly values are valid in that cycle.
- R8: If a second-vector receive value has any bit set other than the victim bit, anomaly goes to 1. It stays 1 until the next accepted start clears it.
- R9: start is accepted only while idle. A start raised during a run or in the done cycle changes neither the vectors, nor the result, nor the done timing, and starts no new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | W | Stored compacted pass/fail byte, bit k = line k passed |
| anomaly | output | 1 | Sticky: a received second vector had a non-victim bit set |
| tx_data | output | W | Vector driven onto the bus under test |
| rx_data | input | W | Value received from the far end of the bus |

## Verification
The bench models the bus with a per-line delay mask: a rising line marked faulty still reads 0 in the cycle it rises. It sweeps all 256 fault combinations and compares each result against a sum computed arithmetically. A wrong test order or a misplaced victim shows up as wrong vectors or a shuffled result. Sampling the receive port one cycle late would hide every fault and yield all ones. A stray-bit mask forces carries: the bench checks the wrapped sum and the sticky flag, and that the flag clears on the next start. A start raised mid-run or during the done cycle must not restart the sequence. If it did, the vectors and the done timing would move.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_PRE    = 2'd1,
        PH_HIT    = 2'd2,
        PH_REPORT = 2'd3
    } phase_e;
endpackage

// File: rtl/rdt_sequencer.sv
module rdt_sequencer
    import rdt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output phase_e                state,
    output logic [$clog2(W)-1:0]  idx,
    output logic                  clear,
    output logic                  hit,
    output logic                  last,
    output logic                  done
);
    localparam int IW = $clog2(W);
    localparam logic [IW-1:0] TOP_LINE = IW'(W - 1);

    phase_e          state_q, state_d;
    logic [IW-1:0]   idx_q, idx_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            PH_IDLE: begin
                if (start) begin
                    state_d = PH_PRE;
                    idx_d   = TOP_LINE;
                end
            end
            PH_PRE: begin
                state_d = PH_HIT;
            end
            PH_HIT: begin
                if (idx_q == '0) begin
                    state_d = PH_REPORT;
                end else begin
                    state_d = PH_PRE;
                    idx_d   = idx_q - 1'b1;
                end
            end
            PH_REPORT: begin
                state_d = PH_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // outputs
    always_comb begin
        state = state_q;
        idx   = idx_q;
        clear = (state_q == PH_IDLE) && start;
        hit   = (state_q == PH_HIT);
        last  = (state_q == PH_HIT) && (idx_q == '0);
        done  = (state_q == PH_REPORT);
    end
endmodule

// File: rtl/rdt_vector_gen.sv
module rdt_vector_gen
    import rdt_pkg::*;
#(
    parameter int W = 8
) (
    input  phase_e                state,
    input  logic [$clog2(W)-1:0]  idx,
    output logic [W-1:0]          victim,
    output logic [W-1:0]          tx_data
);
    localparam int IW = $clog2(W);

    // one-hot decode of the current victim line
    for (genvar g = 0; g < W; g++) begin : g_dec
        assign victim[g] = (idx == IW'(g));
    end

    always_comb begin
        unique case (state)
            PH_PRE:  tx_data = ~victim;
            PH_HIT:  tx_data = victim;
            default: tx_data = '0;
        endcase
    end
endmodule

// File: rtl/rdt_compactor.sv
module rdt_compactor #(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          hit,
    input  logic          last,
    input  logic [W-1:0]  victim,
    input  logic [W-1:0]  rx_data,
    output logic [W-1:0]  result,
    output logic          anomaly
);
    logic [W-1:0] acc_q;
    logic [W-1:0] sum;
    logic         stray;

    always_comb begin
        sum   = acc_q + rx_data;
        stray = |(rx_data & ~victim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            result  <= '0;
            anomaly <= 1'b0;
        end else if (clear) begin
            acc_q   <= '0;
            anomaly <= 1'b0;
        end else if (hit) begin
            acc_q <= sum;
            if (stray) anomaly <= 1'b1;
            if (last)  result  <= sum;
        end
    end
endmodule

// File: rtl/rise_delay_tester.sv
module rise_delay_tester
    import rdt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          done,
    output logic [W-1:0]  result,
    output logic          anomaly,
    output logic [W-1:0]  tx_data,
    input  logic [W-1:0]  rx_data
);
    localparam int IW = $clog2(W);

    phase_e         state;
    logic [IW-1:0]  idx;
    logic           clear, hit, last;
    logic [W-1:0]   victim;

    rdt_sequencer #(.W(W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .state (state),
        .idx   (idx),
        .clear (clear),
        .hit   (hit),
        .last  (last),
        .done  (done)
    );

    rdt_vector_gen #(.W(W)) u_vec (
        .state   (state),
        .idx     (idx),
        .victim  (victim),
        .tx_data (tx_data)
    );

    rdt_compactor #(.W(W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .hit     (hit),
        .last    (last),
        .victim  (victim),
        .rx_data (rx_data),
        .result  (result),
        .anomaly (anomaly)
    );
endmodule

// File: rtl/rise_delay_tester_chk.sv
module rise_delay_tester_chk
    import rdt_pkg::*;
#(
    parameter int W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  done,
    input logic [W-1:0]          result,
    input logic                  anomaly,
    input logic [W-1:0]          tx_data,
    input phase_e                state,
    input logic [$clog2(W)-1:0]  idx
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_IDLE) |-> (tx_data == '0));

    a_r3_pre_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_PRE) |=> (state == PH_HIT));

    a_r3_hit_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HIT) |-> ($countones(tx_data) == 1));

    a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !((state == PH_HIT) && (idx == '0)) |=> $stable(result));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_anomaly_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (anomaly && !(start && (state == PH_IDLE))) |=> anomaly);

    a_r9_report_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_REPORT) |=> (state == PH_IDLE));
endmodule

bind rise_delay_tester rise_delay_tester_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .result  (result),
    .anomaly (anomaly),
    .tx_data (tx_data),
    .state   (state),
    .idx     (idx)
);

// File: tb/rise_delay_tester_tb.sv
module rise_delay_tester_tb;
    localparam int  W          = 8;
    localparam time CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done, anomaly;
    logic [W-1:0]  result, tx_data, rx_data;
    logic [W-1:0]  prev_tx;
    logic [W-1:0]  fault_mask = '0;
    logic [W-1:0]  glitch_mask = '0;
    logic [W-1:0]  last_res = '0;
    int            checks = 0;
    int            errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // bus model: a faulty line that rises this cycle still reads 0
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_tx <= '0;
        else        prev_tx <= tx_data;
    end
    assign rx_data = (tx_data & ~(fault_mask & ~prev_tx)) | glitch_mask;

    rise_delay_tester #(.W(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .done    (done),
        .result  (result),
        .anomaly (anomaly),
        .tx_data (tx_data),
        .rx_data (rx_data)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_result(input logic [W-1:0] fm,
                                                input logic [W-1:0] gm);
        logic [W-1:0] s = '0;
        for (int k = 0; k < W; k++)
            s = s + (((W'(1) << k) & ~fm) | gm);
        return s;
    endfunction

    function automatic bit exp_anom(input logic [W-1:0] gm);
        for (int k = 0; k < W; k++)
            if ((gm & ~(W'(1) << k)) != '0) return 1'b1;
        return 1'b0;
    endfunction

    // poke: line index to raise start during its first vector, W for the done cycle, -1 none
    task automatic run_test(input logic [W-1:0] fm, input logic [W-1:0] gm, input int poke);
        logic [W-1:0] er;
        bit           ea;
        er = exp_result(fm, gm);
        ea = exp_anom(gm);
        fault_mask  = fm;
        glitch_mask = gm;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(anomaly == 1'b0, "R8 cleared on start", anomaly, 0);
        chk(result == last_res, "R6 held into next run", result, last_res);
        for (int k = W - 1; k >= 0; k--) begin
            chk(tx_data == ~(W'(1) << k), "R2 R3 first vector", tx_data, ~(W'(1) << k));
            chk(done == 1'b0, "R7 no early done", done, 0);
            if (poke == k) start = 1'b1;
            @(negedge clk) start = 1'b0;
            chk(tx_data == (W'(1) << k), "R3 second vector", tx_data, W'(1) << k);
            @(negedge clk);
        end
        chk(done == 1'b1, "R7 done timing", done, 1);
        chk(result == er, "R4 R5 compacted result", result, er);
        chk(anomaly == ea, "R8 anomaly at done", anomaly, ea);
        if (poke == W) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(done == 1'b0, "R7 single pulse", done, 0);
        chk(tx_data == '0, "R1 idle bus", tx_data, 0);
        @(negedge clk);
        chk(tx_data == '0, "R9 no restart", tx_data, 0);
        chk(result == er, "R6 result holds", result, er);
        chk(anomaly == ea, "R8 sticky after run", anomaly, ea);
        last_res = er;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(result == '0, "R1 reset result", result, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        chk(anomaly == 1'b0, "R1 reset anomaly", anomaly, 0);
        chk(tx_data == '0, "R1 reset bus", tx_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_data == '0, "R1 idle after reset", tx_data, 0);

        run_test(8'h00, 8'h00, -1);   // R5 clean bus
        run_test(8'h5A, 8'h00, -1);   // R5 mixed faults
        run_test(8'h00, 8'h00, 4);    // R9 start mid-run
        run_test(8'h81, 8'h00, W);    // R9 start during done
        run_test(8'h00, 8'h01, -1);   // R4 R8 carry-producing stray bit
        run_test(8'h00, 8'h00, -1);   // R8 flag cleared by new run
        run_test(8'h10, 8'h40, -1);   // R8 stray plus fault
        for (int m = 0; m < (1 << W); m++)
            run_test(W'(m), 8'h00, -1);   // R5 exhaustive fault sweep

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule